// File: doc/BRIEF.md
# Addressable Latch with Four Modes

An eight-bit register bank that writes one data bit into a position chosen by a binary select address. Two control inputs, both active low, set the mode of each clock cycle. The update control decides whether the addressed bit takes the data. The clear control decides whether the bits that are not addressed keep their values or are driven to zero. Together they give four modes: addressed write, hold, one-hot steering (demultiplexing) and full clear.

All storage is edge-triggered. The mode seen at a rising clock edge is applied at that edge, so a bit that "follows" the data is reloaded on every cycle that its mode persists. There are no transparent latches. A separate asynchronous active-low reset clears the bank.

Top module: `addr_latch`

## Requirements
- R1: With upd_ni=0 and clr_ni=1 (write mode), the next rising edge loads data_i into bit addr_i of q_o. Every other bit keeps its value.
- R2: With upd_ni=1 and clr_ni=1 (hold mode), q_o does not change at the next rising edge, whatever data_i and addr_i are.
- R3: With upd_ni=0 and clr_ni=0 (steer mode), the next rising edge loads data_i into bit addr_i and writes zero into every other bit.
- R4: With upd_ni=1 and clr_ni=0 (clear mode), q_o is all zeros after the next rising edge, whatever data_i and addr_i are.
- R5: The address is plain binary. Value 0 selects q_o[0] and value 7 selects q_o[7]. addr_i[2] has weight 4.
- R6: Driving rst_ni low clears q_o at once, without waiting for a clock edge. q_o stays zero while rst_ni is low.
- R7: When the address changes between cycles of write mode, the write target moves at the next edge. A bit written earlier keeps the last value written to it.
- R8: q_o changes only at rising clock edges. Input changes between edges have no effect on it until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears all bits |
| data_i | input | 1 | Data bit to store |
| addr_i | input | 3 | Binary select of the target bit (ADDR_W) |
| upd_ni | input | 1 | Update control, active low |
| clr_ni | input | 1 | Clear control, active low |
| q_o | output | 8 | Stored bits (NUM_BITS) |

## Verification
The bench builds the block with the default NUM_BITS of 8, so the derived ADDR_W is 3. With that width every address maps to a real bit, and the bench can apply all four modes against all eight addresses and both data values. It preloads a mixed pattern before each of those 64 combinations and compares the result with a model written from the requirements. Directed sequences then load a pattern, hold it, steer it away, check the reset that acts between clock edges, and check that inputs changed between edges have no effect until the next edge.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_STEER = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/addr_latch_mode.sv
module addr_latch_mode
  import addr_latch_pkg::*;
(
  input  logic  upd_ni,
  input  logic  clr_ni,
  output mode_e mode_o
);
  always_comb begin
    unique case ({upd_ni, clr_ni})
      2'b01:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_STEER;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/addr_latch_dec.sv
module addr_latch_dec #(
  parameter int unsigned NUM_BITS = 8,
  parameter int unsigned ADDR_W   = $clog2(NUM_BITS)
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_BITS-1:0] sel_o
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/addr_latch_cell.sv
module addr_latch_cell
  import addr_latch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  sel_i,
  input  logic  data_i,
  output logic  q_o
);
  logic q_d;

  always_comb begin
    unique case (mode_i)
      MODE_WRITE: q_d = sel_i ? data_i : q_o;
      MODE_HOLD:  q_d = q_o;
      MODE_STEER: q_d = sel_i & data_i;
      default:    q_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter  int unsigned NUM_BITS = 8,
  localparam int unsigned ADDR_W   = $clog2(NUM_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                data_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                upd_ni,
  input  logic                clr_ni,
  output logic [NUM_BITS-1:0] q_o
);
  mode_e               mode;
  logic [NUM_BITS-1:0] sel;

  addr_latch_mode u_mode (
    .upd_ni (upd_ni),
    .clr_ni (clr_ni),
    .mode_o (mode)
  );

  addr_latch_dec #(.NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
    addr_latch_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .sel_i  (sel[i]),
      .data_i (data_i),
      .q_o    (q_o[i])
    );
  end
endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int unsigned NUM_BITS = 8,
  parameter int unsigned ADDR_W   = $clog2(NUM_BITS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                data_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                upd_ni,
  input logic                clr_ni,
  input logic [NUM_BITS-1:0] q_o
);
  // R1 / R7: addressed bit takes data, others untouched
  p_write_tgt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_ni && clr_ni) |=> q_o[$past(addr_i)] == $past(data_i));
  p_write_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_ni && clr_ni) |=>
      ((q_o ^ $past(q_o)) & ~(NUM_BITS'(1) << $past(addr_i))) == '0);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_ni && clr_ni) |=> $stable(q_o));
  p_steer_tgt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_ni && !clr_ni) |=> q_o == (NUM_BITS'($past(data_i)) << $past(addr_i)));
  p_steer_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_ni && !clr_ni) |=> $onehot0(q_o));
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_ni && !clr_ni) |=> q_o == '0);
  p_reset_r6: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0);
endmodule

bind addr_latch addr_latch_chk #(.NUM_BITS(NUM_BITS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .data_i (data_i),
  .addr_i (addr_i),
  .upd_ni (upd_ni),
  .clr_ni (clr_ni),
  .q_o    (q_o)
);

// File: tb/addr_latch_bench.sv
`timescale 1ns/1ps
module addr_latch_bench;
  localparam int unsigned NB = 8;
  localparam int unsigned AW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          data_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          upd_ni = 1'b1;
  logic          clr_ni = 1'b1;
  logic [NB-1:0] q_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  addr_latch u_addr_latch (
    .clk_i (clk_i), .rst_ni (rst_ni), .data_i (data_i), .addr_i (addr_i),
    .upd_ni (upd_ni), .clr_ni (clr_ni), .q_o (q_o)
  );

  // {upd_n, clr_n, addr, data, expected q, req}
  typedef struct packed {
    logic       upd_n;
    logic       clr_n;
    logic [2:0] addr;
    logic       data;
    logic [7:0] exp_q;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b1, 3'd3, 1'b1, 8'h08, 4'd1},  // R1 write
    '{1'b0, 1'b1, 3'd7, 1'b1, 8'h88, 4'd5},  // R5 top bit
    '{1'b0, 1'b1, 3'd0, 1'b1, 8'h89, 4'd5},  // R5 bottom bit
    '{1'b0, 1'b1, 3'd3, 1'b0, 8'h81, 4'd7},  // R7 rewrite earlier bit
    '{1'b1, 1'b1, 3'd5, 1'b1, 8'h81, 4'd2},  // R2 hold
    '{1'b0, 1'b1, 3'd5, 1'b1, 8'hA1, 4'd1},  // R1
    '{1'b1, 1'b1, 3'd2, 1'b1, 8'hA1, 4'd2},  // R2
    '{1'b0, 1'b0, 3'd2, 1'b1, 8'h04, 4'd3},  // R3 steer clears others
    '{1'b0, 1'b0, 3'd6, 1'b0, 8'h00, 4'd3},  // R3
    '{1'b0, 1'b1, 3'd4, 1'b1, 8'h10, 4'd7},  // R7
    '{1'b0, 1'b1, 3'd1, 1'b1, 8'h12, 4'd7},  // R7 target moved
    '{1'b1, 1'b0, 3'd1, 1'b1, 8'h00, 4'd4}   // R4 clear
  };

  task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: q_o=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic un, input logic cn, input logic [AW-1:0] a, input logic d);
    @(negedge clk_i);
    upd_ni = un; clr_ni = cn; addr_i = a; data_i = d;
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [NB-1:0] model(input logic [NB-1:0] q, input logic un,
                                          input logic cn, input logic [AW-1:0] a, input logic d);
    logic [NB-1:0] one = NB'(1) << a;
    case ({un, cn})
      2'b01:   return d ? (q | one) : (q & ~one);
      2'b11:   return q;
      2'b00:   return d ? one : '0;
      default: return '0;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: q_o=%h expected=done", q_o);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] exp;
    repeat (3) @(posedge clk_i);
    #1;
    check("R6 reset state", q_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    foreach (VECS[i]) begin
      step(VECS[i].upd_n, VECS[i].clr_n, VECS[i].addr, VECS[i].data);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), q_o, VECS[i].exp_q);
    end

    // exhaustive: 4 modes x 8 addresses x 2 data values on a preloaded 5A pattern
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 8; a++) begin
        for (int d = 0; d < 2; d++) begin
          for (int b = 0; b < 8; b++) step(1'b0, 1'b1, AW'(b), (8'h5A >> b) & 1'b1);
          check("R5 preload", q_o, 8'h5A);
          exp = model(8'h5A, m[1], m[0], AW'(a), d[0]);
          step(m[1], m[0], AW'(a), d[0]);
          check($sformatf("R1-4 sweep mode=%0d addr=%0d data=%0d", m, a, d), q_o, exp);
        end
      end
    end

    // load, hold, then steer clears the unselected bits
    for (int b = 0; b < 8; b++) step(1'b0, 1'b1, AW'(b), 1'b1);
    check("R1 load all ones", q_o, 8'hFF);
    step(1'b1, 1'b1, 3'd0, 1'b0);
    step(1'b1, 1'b1, 3'd4, 1'b0);
    check("R2 held pattern", q_o, 8'hFF);
    step(1'b0, 1'b0, 3'd6, 1'b1);
    check("R3 steer clears others", q_o, 8'h40);

    // R8: inputs changed between edges do nothing until the next edge
    @(negedge clk_i);
    upd_ni = 1'b1; clr_ni = 1'b0;
    #1;
    check("R8 no change before edge", q_o, 8'h40);
    @(posedge clk_i);
    #1;
    check("R8 applied at edge", q_o, 8'h00);

    // R6: asynchronous reset mid-cycle
    step(1'b0, 1'b1, 3'd2, 1'b1);
    step(1'b1, 1'b1, 3'd2, 1'b1);
    check("R6 pattern before reset", q_o, 8'h04);
    @(negedge clk_i);
    #0.5;
    rst_ni = 1'b0;
    #0.5;
    check("R6 async clear", q_o, 8'h00);
    upd_ni = 1'b0; clr_ni = 1'b1; addr_i = 3'd1; data_i = 1'b1;
    @(posedge clk_i);
    #1;
    check("R6 held in reset", q_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    check("R1 write after reset", q_o, 8'h02);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule